// File: doc/BRIEF.md
# Periodic Tick Timer with Selectable Pre-Divider

This block produces a periodic tick from the system clock. The clock first passes through a pre-divider that divides by either 4 or 256. The divided ticks then step a 16-bit down-counter. When the counter is at zero, the next divided tick reloads it from a programmable period register and marks one expiry. One full period is therefore (period value + 1) divided ticks. The shortest period is one divided tick, at a period value of 0x0000. The longest is 65536 divided ticks, at 0xFFFF.

Each expiry sets a sticky event flag. Software clears the flag by writing a one to its bit. The interrupt output is high while the flag is set and the interrupt-enable bit is set. A run bit gates the timer: when it is clear, the counter holds its value and the pre-divider is held at zero.

Software reaches the block through a two-register port:
- A period register. Writing it also loads the counter at once and restarts the pre-divider.
- A control register, with these bits:
  - bit 0: run.
  - bit 1: interrupt enable.
  - bit 2: slow divide. 0 divides by 4, 1 divides by 256.
  - bit 3: event flag. Reads the flag; writing 1 clears it.

Top module: `ptick_timer`

## Requirements
- R1: After reset the period register (reg_sel 0) reads 0xFFFF, the control register (reg_sel 1) reads 0x0000 and irq is low.
- R2: With period value N and the divide by 4 selected (control bit 2 = 0), the first expiry follows 4*(N+1) clock cycles after the edge that sets run (control bit 0). Further expiries follow every 4*(N+1) cycles, with the counter reloading from the period register.
- R3: With control bit 2 = 1 the pre-divider divides by 256, so a period value N gives expiries every 256*(N+1) cycles.
- R4: A period value of 0x0000 gives the shortest period, one divided tick (4 cycles with the divide by 4).
- R5: While run is clear the counter holds its value and the pre-divider is held at zero. No expiry occurs, and counting resumes from the held value when run is set again.
- R6: Every expiry sets the event flag, readable at control bit 3. The flag stays set until it is cleared.
- R7: irq equals the event flag ANDed with interrupt enable (control bit 1). With interrupt enable clear, the flag still sets but irq stays low.
- R8: Writing the control register with bit 3 = 1 clears the flag. Writing it with bit 3 = 0 leaves the flag unchanged.
- R9: An expiry in the same cycle as a clearing write leaves the flag set.
- R10: Writing the period register stores the value, which reads back, loads the counter immediately and restarts the pre-divider. The next expiry follows div*(V+1) cycles after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 period register, 1 control register |
| wr_data | input | 16 | Write data |
| rd_sel | input | 1 | Read target: 0 period register, 1 control register |
| rd_data | output | 16 | Read data (combinational) |
| irq | output | 1 | Interrupt request, flag AND interrupt enable |

## Verification
Some internal faults move the time of an expiry, for example a pre-divider wrapping at the wrong count or a counter that does not reload. These appear at irq as a rising edge one or more cycles away from div*(N+1), within the first period. A flag that fails to stick, to clear or to win a collision with a clear shows up in control bit 3 on the read taken right after the write concerned. A counter that keeps running while stopped produces an expiry during the stopped window, or a late expiry after resume.

// File: rtl/ptm_pkg.sv
package ptm_pkg;

    // control register bit positions (software visible)
    localparam int CTL_W     = 4;
    localparam int RUN_BIT   = 0;
    localparam int IE_BIT    = 1;
    localparam int SLOW_BIT  = 2;
    localparam int FLAG_BIT  = 3;

    typedef struct packed {
        logic flag;
        logic slow;
        logic ie;
        logic run;
    } ctl_t;

    typedef enum logic {
        SEL_PERIOD = 1'b0,
        SEL_CTL    = 1'b1
    } reg_sel_e;

    function automatic int wider(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // terminal count of a divide-by-2**log2 stage
    function automatic int div_last(input int log2);
        return (1 << log2) - 1;
    endfunction

endpackage

// File: rtl/ptm_prescaler.sv
module ptm_prescaler
    import ptm_pkg::*;
#(
    parameter int FAST_LOG2 = 2,
    parameter int SLOW_LOG2 = 8,
    parameter int PRE_W     = wider(FAST_LOG2, SLOW_LOG2)
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic slow,
    input  logic restart,
    output logic tick
);

    localparam logic [PRE_W-1:0] LAST_FAST = PRE_W'(div_last(FAST_LOG2));
    localparam logic [PRE_W-1:0] LAST_SLOW = PRE_W'(div_last(SLOW_LOG2));

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] last;

    always_comb begin
        last = slow ? LAST_SLOW : LAST_FAST;
        // >= so a switch to the short divide while running still wraps
        tick = run && !restart && (pre_q >= last);
    end

    always_ff @(posedge clk) begin
        if (rst || !run || restart) begin
            pre_q <= '0;
        end else if (tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // R5
    // run_start_chk
    run_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> (pre_q == '0));

endmodule

// File: rtl/ptm_counter.sv
module ptm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_q;
    logic             at_zero;

    always_comb begin
        at_zero = (cnt_q == '0);
        expire  = tick && at_zero && !load;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '1;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick) begin
            cnt_q <= at_zero ? reload_val : (cnt_q - 1'b1);
        end
    end

    // R5
    // hold_chk
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(cnt_q));

    // R2
    // reload_chk
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        expire |=> (cnt_q == $past(reload_val)));

endmodule

// File: rtl/ptm_regs.sv
module ptm_regs
    import ptm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             rd_sel,
    input  logic             expire,
    output ctl_t             ctl,
    output logic [CNT_W-1:0] reload,
    output logic             load,
    output logic [CNT_W-1:0] rd_data,
    output logic             irq
);

    logic wr_ctl;
    logic clear_req;

    always_comb begin
        load      = wr_en && (reg_sel_e'(wr_sel) == SEL_PERIOD);
        wr_ctl    = wr_en && (reg_sel_e'(wr_sel) == SEL_CTL);
        clear_req = wr_ctl && wr_data[FLAG_BIT];
        irq       = ctl.flag && ctl.ie;
        if (reg_sel_e'(rd_sel) == SEL_CTL) begin
            rd_data = {{(CNT_W-CTL_W){1'b0}}, ctl};
        end else begin
            rd_data = reload;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reload <= '1;
            ctl    <= '0;
        end else begin
            if (load) begin
                reload <= wr_data;
            end
            if (wr_ctl) begin
                ctl.run  <= wr_data[RUN_BIT];
                ctl.ie   <= wr_data[IE_BIT];
                ctl.slow <= wr_data[SLOW_BIT];
            end
            // a fresh expiry outranks a clearing write
            if (expire) begin
                ctl.flag <= 1'b1;
            end else if (clear_req) begin
                ctl.flag <= 1'b0;
            end
        end
    end

    // R6
    // flag_set_chk
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        expire |=> ctl.flag);

    // R8
    // flag_clr_chk
    flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl.flag) |-> $past(wr_en && wr_sel && wr_data[FLAG_BIT]));

    // R9
    // collide_chk
    collide_chk: assert property (@(posedge clk) disable iff (rst)
        (expire && clear_req) |=> ctl.flag);

endmodule

// File: rtl/ptick_timer.sv
module ptick_timer
    import ptm_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int FAST_LOG2 = 2,
    parameter int SLOW_LOG2 = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             rd_sel,
    output logic [CNT_W-1:0] rd_data,
    output logic             irq
);

    localparam int PRE_W = wider(FAST_LOG2, SLOW_LOG2);

    ctl_t             ctl;
    logic [CNT_W-1:0] reload;
    logic             load;
    logic             tick;
    logic             expire;

    ptm_regs #(.CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_sel  (rd_sel),
        .expire  (expire),
        .ctl     (ctl),
        .reload  (reload),
        .load    (load),
        .rd_data (rd_data),
        .irq     (irq)
    );

    ptm_prescaler #(
        .FAST_LOG2 (FAST_LOG2),
        .SLOW_LOG2 (SLOW_LOG2),
        .PRE_W     (PRE_W)
    ) u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (ctl.run),
        .slow    (ctl.slow),
        .restart (load),
        .tick    (tick)
    );

    ptm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .load       (load),
        .load_val   (wr_data),
        .reload_val (reload),
        .expire     (expire)
    );

endmodule

// File: tb/sim_ptick_timer.sv
`timescale 1ns/1ps
module sim_ptick_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [15:0] rd_data;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;
    int exp_q[$];
    bit irq_q = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ptick_timer u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    // drive a write; it lands on the next rising edge, returns that edge number
    task automatic wr(input logic sel, input logic [15:0] d, output int at);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(posedge clk); #1;
        at = cyc;
        wr_en = 1'b0;
    endtask

    task automatic at_cycle(input int c);
        @(negedge clk);
        while (cyc < c) @(negedge clk);
    endtask

    // monitor: every rising irq must match the next expected edge
    always @(negedge clk) begin
        if (!rst) begin
            if (irq && !irq_q) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 unexpected irq", cyc, -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(cyc == e, "R2 irq timing", cyc, e);
                end
            end
            irq_q = irq;
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        chk(1'b0, "watchdog", cyc, 0);
        finish_run();
    end

    initial begin
        int e, f, w, d;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(posedge clk); #1;

        // R1 reset state
        rd_sel = 1'b0; #0.1;
        chk(rd_data == 16'hFFFF, "R1 period reset", rd_data, 16'hFFFF);
        rd_sel = 1'b1; #0.1;
        chk(rd_data == 16'h0000, "R1 ctrl reset", rd_data, 0);
        chk(irq == 1'b0, "R1 irq reset", irq, 0);

        // R2 periodic, N=2, divide by 4 -> 12 cycles
        wr(1'b0, 16'd2, d);
        wr(1'b1, 16'h0003, e);
        for (int k = 1; k <= 3; k++) exp_q.push_back(e + 12 * k);
        for (int k = 1; k <= 3; k++) begin
            at_cycle(e + 12 * k - 1);
            chk(irq == 1'b0, "R2 before expiry", irq, 0);
            at_cycle(e + 12 * k);
            chk(irq == 1'b1, "R2 at expiry", irq, 1);
            wr(1'b1, 16'h000B, d);
        end
        wr(1'b1, 16'h0008, d);

        // R4 shortest period, N=0 -> 4 cycles
        wr(1'b0, 16'd0, d);
        wr(1'b1, 16'h0003, e);
        exp_q.push_back(e + 4);
        exp_q.push_back(e + 8);
        at_cycle(e + 4);
        chk(irq == 1'b1, "R4 first tick", irq, 1);
        wr(1'b1, 16'h000B, d);
        at_cycle(e + 8);
        chk(irq == 1'b1, "R4 second tick", irq, 1);
        wr(1'b1, 16'h0008, d);

        // R3 divide by 256, N=1 -> 512 cycles
        wr(1'b0, 16'd1, d);
        wr(1'b1, 16'h0007, e);
        exp_q.push_back(e + 512);
        at_cycle(e + 511);
        chk(irq == 1'b0, "R3 before expiry", irq, 0);
        at_cycle(e + 512);
        chk(irq == 1'b1, "R3 at expiry", irq, 1);
        wr(1'b1, 16'h0008, d);

        // R5 stop and resume, N=3 (16 cycles); stop after two ticks
        wr(1'b0, 16'd3, d);
        wr(1'b1, 16'h0003, e);
        at_cycle(e + 7);
        wr(1'b1, 16'h0002, d);
        at_cycle(e + 40);
        chk(irq == 1'b0, "R5 no expiry while stopped", irq, 0);
        wr(1'b1, 16'h0003, f);
        exp_q.push_back(f + 8);
        at_cycle(f + 7);
        chk(irq == 1'b0, "R5 resumed before expiry", irq, 0);
        at_cycle(f + 8);
        chk(irq == 1'b1, "R5 resumed from held count", irq, 1);
        wr(1'b1, 16'h0008, d);

        // R6 R7 R8 R9 flag without interrupt enable, N=0
        wr(1'b0, 16'd0, d);
        wr(1'b1, 16'h0001, e);
        rd_sel = 1'b1;
        at_cycle(e + 5);
        chk(rd_data[3] == 1'b1, "R6 flag sticky", rd_data[3], 1);
        chk(irq == 1'b0, "R7 irq masked", irq, 0);
        wr(1'b1, 16'h0001, d);
        chk(rd_data[3] == 1'b1, "R8 zero write keeps flag", rd_data[3], 1);
        wr(1'b1, 16'h0009, d);
        chk(rd_data[3] == 1'b0, "R8 one write clears flag", rd_data[3], 0);
        wr(1'b1, 16'h0009, d);
        chk(d == e + 8, "R9 collision edge", d, e + 8);
        chk(rd_data[3] == 1'b1, "R9 expiry wins over clear", rd_data[3], 1);
        wr(1'b1, 16'h0008, d);
        chk(rd_data == 16'h0000, "R8 disable and clear", rd_data, 0);

        // R10 period write restarts the count, N=10 then V=1
        wr(1'b0, 16'd10, d);
        wr(1'b1, 16'h0003, e);
        at_cycle(e + 20);
        wr(1'b0, 16'd1, w);
        exp_q.push_back(w + 8);
        rd_sel = 1'b0; #0.1;
        chk(rd_data == 16'd1, "R10 readback", rd_data, 1);
        rd_sel = 1'b1;
        at_cycle(w + 7);
        chk(irq == 1'b0, "R10 before expiry", irq, 0);
        at_cycle(w + 8);
        chk(irq == 1'b1, "R10 restarted period", irq, 1);
        wr(1'b1, 16'h0008, d);

        repeat (20) @(posedge clk);
        #1;
        chk(exp_q.size() == 0, "R2 missing expiries", exp_q.size(), 0);
        finish_run();
    end

endmodule